// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Bus Link

This block joins a bus master and a bus slave that run on unrelated clocks. They exchange single words over a parallel bus. The bus carries an address, a direction bit and data in each direction. Two control wires govern each transfer: a request driven by the master and an acknowledge driven by the slave. Neither side assumes anything about the other's timing. Every step of a transfer waits until the opposite control wire has been seen through a two-flop synchroniser in the local clock.

The master accepts one read or write command at a time from a local port. It puts the command on the bus, raises request and waits for acknowledge. It then drops request and waits until acknowledge is low again before it takes the next command. The slave holds a small register file. It waits a fixed number of its own cycles before it answers, which models a slow device. On a read it places the stored word on the bus and only afterwards raises acknowledge.

Top module: `hs_bus_top`

## Requirements
- R1: While either reset is high and after both are released, busy, rd_valid, request and acknowledge are all low.
- R2: The master sets address, direction and write data one master cycle before request rises, and holds them unchanged while request is high.
- R3: A write stores cmd_wdata at cmd_addr in the slave register file, and a later read of that address returns it.
- R4: Request falls only after the master has seen acknowledge high. Acknowledge falls only after the slave has seen request low. Every accepted command completes with busy low again within 200 master cycles.
- R5: On a read the slave drives the word before acknowledge rises and holds it while acknowledge is high. The master captures it on the synchronised rise of acknowledge and pulses rd_valid high for one master cycle, with rd_data carrying the word.
- R6: busy is high from the master cycle after cmd_valid is accepted while idle, and it stays high until the master has seen acknowledge low again.
- R7: cmd_valid while busy is high is ignored. In particular, an ignored write does not change the register file.
- R8: The slave waits RESP_DELAY slave cycles (0 to 15, larger values clipped to 15) after seeing request before it performs the access. All results are identical for any delay, and a larger delay lengthens busy accordingly.
- R9: A write command never produces an rd_valid pulse.
- R10: Reset clears every location of the register file to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master-side clock |
| rst_m | input | 1 | Master-side synchronous reset, active high |
| clk_s | input | 1 | Slave-side clock |
| rst_s | input | 1 | Slave-side synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Register file address |
| cmd_wdata | input | DW | Data for a write |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle pulse when read data is captured |
| rd_data | output | DW | Last captured read word |

## Verification
A corrupted master state would show up as busy failing to rise on the cycle after acceptance, or as busy never falling. Either is visible within one master cycle, or when the 200-cycle completion bound expires. A broken slave sequence or a stale bus register would show up at the next read of the affected address: the wrong word, or a missing or extra rd_valid pulse. The bench sweeps every address with two patterns. It also runs two copies at the extreme delays, so a fault that depends on delay shows as a difference between the copies or as a latency that fails to grow.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int MAX_DELAY = 15;
    localparam int DLY_W     = $clog2(MAX_DELAY + 1);

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_SETUP = 2'd1,
        M_REQ   = 2'd2,
        M_REL   = 2'd3
    } mst_state_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_DRIVE = 2'd2,
        S_HOLD  = 2'd3
    } slv_state_e;

    function automatic int clip_delay(int d);
        if (d < 0)
            return 0;
        else if (d > MAX_DELAY)
            return MAX_DELAY;
        else
            return d;
    endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
    import hs_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          busy,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          ack_seen
);
    mst_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= M_IDLE;
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (state)
                M_IDLE: begin
                    if (cmd_valid) begin
                        bus_we    <= cmd_write;
                        bus_addr  <= cmd_addr;
                        bus_wdata <= cmd_wdata;
                        state     <= M_SETUP;
                    end
                end
                M_SETUP: begin
                    bus_req <= 1'b1;
                    state   <= M_REQ;
                end
                M_REQ: begin
                    if (ack_seen) begin
                        if (!bus_we) begin
                            rd_data  <= bus_rdata;
                            rd_valid <= 1'b1;
                        end
                        bus_req <= 1'b0;
                        state   <= M_REL;
                    end
                end
                M_REL: begin
                    if (!ack_seen) state <= M_IDLE;
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    assign busy = (state != M_IDLE);
endmodule

// File: rtl/hs_slave.sv
module hs_slave
    import hs_pkg::*;
#(
    parameter int AW         = 4,
    parameter int DW         = 8,
    parameter int RESP_DELAY = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_seen,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_ack
);
    localparam int DEPTH     = 1 << AW;
    localparam int EFF_DELAY = clip_delay(RESP_DELAY);

    logic [DW-1:0]    regs [DEPTH];
    slv_state_e       state;
    logic [DLY_W-1:0] cnt;
    logic             cap_we;
    logic [AW-1:0]    cap_addr;
    logic [DW-1:0]    cap_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            cap_we    <= 1'b0;
            cap_addr  <= '0;
            cap_wdata <= '0;
            bus_rdata <= '0;
            bus_ack   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_seen) begin
                        cap_we    <= bus_we;
                        cap_addr  <= bus_addr;
                        cap_wdata <= bus_wdata;
                        cnt       <= DLY_W'(EFF_DELAY);
                        state     <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (cnt == '0) begin
                        if (cap_we) regs[cap_addr] <= cap_wdata;
                        else        bus_rdata      <= regs[cap_addr];
                        state <= S_DRIVE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_DRIVE: begin
                    bus_ack <= 1'b1;
                    state   <= S_HOLD;
                end
                S_HOLD: begin
                    if (!req_seen) begin
                        bus_ack <= 1'b0;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_bus_top.sv
module hs_bus_top #(
    parameter int AW         = 4,
    parameter int DW         = 8,
    parameter int RESP_DELAY = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_m,
    input  logic          rst_m,
    input  logic          clk_s,
    input  logic          rst_s,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          busy,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic          bus_req;
    logic          bus_ack;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          ack_in_m;
    logic          req_in_s;

    hs_master #(.AW(AW), .DW(DW)) u_master (
        .clk       (clk_m),
        .rst       (rst_m),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ack_seen  (ack_in_m)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk_m),
        .rst (rst_m),
        .d   (bus_ack),
        .q   (ack_in_m)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk_s),
        .rst (rst_s),
        .d   (bus_req),
        .q   (req_in_s)
    );

    hs_slave #(.AW(AW), .DW(DW), .RESP_DELAY(RESP_DELAY)) u_slave (
        .clk       (clk_s),
        .rst       (rst_s),
        .req_seen  (req_in_s),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );
endmodule

// File: rtl/hs_bus_chk.sv
module hs_bus_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk_m,
    input logic          rst_m,
    input logic          clk_s,
    input logic          rst_s,
    input logic          cmd_valid,
    input logic          busy,
    input logic          rd_valid,
    input logic          bus_req,
    input logic          bus_ack,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          ack_in_m,
    input logic          req_in_s
);
    p_bus_stable_r2: assert property (@(posedge clk_m) disable iff (rst_m)
        (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_req_setup_r2: assert property (@(posedge clk_m) disable iff (rst_m)
        $rose(bus_req) |-> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_req_hold_r4: assert property (@(posedge clk_m) disable iff (rst_m)
        $fell(bus_req) |-> $past(ack_in_m));

    p_ack_release_r4: assert property (@(posedge clk_s) disable iff (rst_s)
        $fell(bus_ack) |-> !$past(req_in_s));

    p_ack_answers_r4: assert property (@(posedge clk_s) disable iff (rst_s)
        $rose(bus_ack) |-> $past(req_in_s));

    p_rdata_hold_r5: assert property (@(posedge clk_s) disable iff (rst_s)
        (bus_ack && $past(bus_ack) && !bus_we) |-> $stable(bus_rdata));

    p_busy_start_r6: assert property (@(posedge clk_m) disable iff (rst_m)
        $rose(busy) |-> $past(cmd_valid));

    p_busy_end_r6: assert property (@(posedge clk_m) disable iff (rst_m)
        $fell(busy) |-> (!$past(ack_in_m) && !bus_req));

    p_no_write_pulse_r9: assert property (@(posedge clk_m) disable iff (rst_m)
        rd_valid |-> !bus_we);
endmodule

bind hs_bus_top hs_bus_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk_m     (clk_m),
    .rst_m     (rst_m),
    .clk_s     (clk_s),
    .rst_s     (rst_s),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ack_in_m  (ack_in_m),
    .req_in_s  (req_in_s)
);

// File: tb/hs_bus_top_tb.sv
`timescale 1ns/1ps
module hs_bus_top_tb;
    localparam int AW = 4;
    localparam int DW = 8;

    logic clk_m = 1'b0;
    logic clk_s = 1'b0;
    logic rst_m = 1'b1;
    logic rst_s = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr  = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          busy, busy0, rd_valid, rd_valid0;
    logic [DW-1:0] rd_data, rd_data0;

    int checks = 0;
    int fails  = 0;
    int rv_cnt = 0, rv0_cnt = 0;
    logic [DW-1:0] rv_last = '0, rv0_last = '0;
    int cyc_slow, cyc_fast;

    always #2.5 clk_m = ~clk_m;
    always #3.5 clk_s = ~clk_s;

    hs_bus_top #(.AW(AW), .DW(DW), .RESP_DELAY(15)) u_dut (
        .clk_m(clk_m), .rst_m(rst_m), .clk_s(clk_s), .rst_s(rst_s),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    hs_bus_top #(.AW(AW), .DW(DW), .RESP_DELAY(0)) u_dut0 (
        .clk_m(clk_m), .rst_m(rst_m), .clk_s(clk_s), .rst_s(rst_s),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .busy(busy0), .rd_valid(rd_valid0), .rd_data(rd_data0)
    );

    always @(negedge clk_m) begin
        if (!rst_m) begin
            if (rd_valid)  begin rv_cnt++;  rv_last  = rd_data;  end
            if (rd_valid0) begin rv0_cnt++; rv0_last = rd_data0; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic run_cmd(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk_m);
        cmd_valid = 1'b1; cmd_write = we; cmd_addr = a; cmd_wdata = d;
        @(negedge clk_m);
        cmd_valid = 1'b0;
        check(busy && busy0, "R6 busy after accept", {busy, busy0}, 3);
        cyc_slow = 1; cyc_fast = 1;
        while (busy || busy0) begin
            @(negedge clk_m);
            if (busy)  cyc_slow++;
            if (busy0) cyc_fast++;
        end
        check(cyc_slow <= 200 && cyc_fast <= 200, "R4 completion bound", cyc_slow, 200);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        int b = rv_cnt;
        int b0 = rv0_cnt;
        run_cmd(1'b0, a, '0);
        check(rv_cnt == b + 1 && rv0_cnt == b0 + 1, "R5 one rd_valid per read",
              rv_cnt - b + rv0_cnt - b0, 2);
        check(rv_last == exp, req, rv_last, exp);
        check(rv0_last == exp, {req, " R8 zero delay"}, rv0_last, exp);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int b = rv_cnt;
        int b0 = rv0_cnt;
        run_cmd(1'b1, a, d);
        check(rv_cnt == b && rv0_cnt == b0, "R9 no rd_valid on write",
              rv_cnt - b + rv0_cnt - b0, 0);
    endtask

    function automatic logic [DW-1:0] pat_a(int a);
        return DW'((a * 37 + 11) ^ 8'h5A);
    endfunction

    initial begin
        repeat (150000) @(posedge clk_m);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (6) @(negedge clk_m);
        check(!busy && !busy0 && !rd_valid && !rd_valid0, "R1 during reset",
              {busy, busy0, rd_valid, rd_valid0}, 0);
        rst_m = 1'b0;
        rst_s = 1'b0;
        repeat (4) @(negedge clk_m);
        check(!busy && !busy0 && !rd_valid && !rd_valid0, "R1 after reset",
              {busy, busy0, rd_valid, rd_valid0}, 0);

        for (int a = 0; a < (1 << AW); a++) do_read(AW'(a), '0, "R10 cleared");

        for (int a = 0; a < (1 << AW); a++) do_write(AW'(a), pat_a(a));
        for (int a = 0; a < (1 << AW); a++) do_read(AW'(a), pat_a(a), "R2,R3 pattern A");

        for (int a = (1 << AW) - 1; a >= 0; a--) begin
            do_write(AW'(a), ~pat_a(a));
            do_read(AW'(a), ~pat_a(a), "R3 back-to-back");
        end

        // R7: command during a busy transfer is dropped
        @(negedge clk_m);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd3; cmd_wdata = 8'h11;
        @(negedge clk_m);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk_m);
        check(busy && busy0, "R7 still busy", {busy, busy0}, 3);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd3; cmd_wdata = 8'hEE;
        @(negedge clk_m);
        cmd_valid = 1'b0;
        while (busy || busy0) @(negedge clk_m);
        repeat (3) @(negedge clk_m);
        check(!busy && !busy0, "R7 ignored cmd not started", {busy, busy0}, 0);
        do_read(4'd3, 8'h11, "R7 ignored write");

        // R8: latency grows with delay, results equal
        do_read(4'd5, ~pat_a(5), "R8 data");
        check(cyc_slow >= cyc_fast + 15, "R8 latency", cyc_slow, cyc_fast + 15);

        finish_run();
    end
endmodule